// File: doc/BRIEF.md
# Windowed Address Translator

This block sits between a core and physical memory and turns each core virtual address into a physical address through a small, fixed set of memory windows. Window `i` owns the virtual slot that starts at `BASE + i * 2^SLOT_SHIFT` and is `2^SLOT_SHIFT` bytes wide. A host programs three things for each window through a 32-bit register port: the physical start address, the usable length, and a permission mask. The block stores the physical start as a relocation addend relative to the slot base. It stores the length as the written value plus one.

Every core access presents an address and an access type. In the same cycle, the block returns the translated physical address and a fault flag. A fault is one of three classes. No window means the address falls outside every slot. Out of range means the offset inside the slot is at or beyond the programmed length. No permission means the window's mask shares no bit with the access type. A qualified fault raises a one-cycle event, which the run-control logic uses as its data-fault trigger to freeze and reset the core. A registered output keeps the class of the most recent faulting access, so the host can read it after the core has stopped.

Top module: `xlt_window_unit`

## Requirements
- R1: After reset, window `i` reads back a start of `BASE + i*2^SLOT_SHIFT`, a length of `2^SLOT_SHIFT`, a permission mask of `PRIV_RST` (default 3'b111), and `fault_class` is 0.
- R2: Writing the start field of window `i` makes the field read back the written value. Any in-range access in that slot then translates to `written_start + (vaddr - slot_base)`, with arithmetic modulo 2^32.
- R3: Writing the length field with `v` sets the usable length to `v+1`, modulo 2^32. The length field then reads `v+1`.
- R4: The permission field holds 3 bits, taken from `wdata[2:0]`. Reads return those bits with bits 31:3 zero.
- R5: Window registers sit at byte offset `1024 + 16*i`. The start field is at +0, the length field at +4 and the permission field at +8. Offset +12, and any offset with `reg_addr[1:0] != 0`, reads zero and ignores writes.
- R6: An offset with `reg_addr[11:10] != 2'b01`, or a window index `reg_addr[9:4] >= NUM_WIN`, reads zero, and a write to it changes no window.
- R7: An address below `BASE`, or whose slot index `(addr-BASE) >> SLOT_SHIFT` is `NUM_WIN` or more, faults with class 1 (no window).
- R8: An address inside a window's slot whose offset is at or beyond that window's length faults with class 2 (out of range).
- R9: Access types are encoded read = 3'b001, write = 3'b010 and execute = 3'b100. If the window's mask ANDed with `acc_type` is zero, the access faults with class 3 (no permission).
- R10: When several fault conditions hold, no-window wins over out-of-range, and out-of-range wins over no-permission.
- R11: `fault_class` takes the class of a faulting access on the clock edge where `acc_valid` is high. It keeps its value across non-faulting or unqualified cycles.
- R12: `acc_fault` reflects the address and type whether or not `acc_valid` is high. `fault_event` is high exactly when `acc_valid` and `acc_fault` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 12 | Host byte offset in the 4 KB register space |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data (combinational on reg_addr) |
| acc_valid | input | 1 | Core access qualifier |
| acc_addr | input | 32 | Core virtual address |
| acc_type | input | 3 | Access type: bit0 read, bit1 write, bit2 execute |
| acc_paddr | output | 32 | Translated physical address |
| acc_fault | output | 1 | Translation fault for the presented address and type |
| fault_event | output | 1 | Qualified fault, feeding the data-fault event |
| fault_class | output | 2 | Last fault class: 0 none, 1 no window, 2 out of range, 3 no permission |

## Verification
A corrupted addend shows up at once as a wrong `acc_paddr` on the first permitted access to that slot. A corrupted length or permission mask shows up as a wrong fault flag at the boundary offsets `len-1` and `len`, or for a single access type. The bench probes those exact offsets for every window and every type, so state damaged by a stray write is seen on the next translation. A bad capture of the fault class appears one edge later on `fault_class`, and a failure to hold it appears on the first clean access that follows.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

  localparam int XA_W   = 32;
  localparam int PRIV_W = 3;

  typedef enum logic [1:0] {
    FC_NONE  = 2'd0,
    FC_NOWIN = 2'd1,
    FC_RANGE = 2'd2,
    FC_PERM  = 2'd3
  } fault_cls_e;

  // Virtual base address of the slot owned by window idx.
  function automatic logic [XA_W-1:0] slot_vbase(input logic [XA_W-1:0] base,
                                                 input int idx,
                                                 input int shift);
    return base + (XA_W'(idx) << shift);
  endfunction

  // Relocation addend kept for a programmed physical start.
  function automatic logic [XA_W-1:0] start_to_addend(input logic [XA_W-1:0] pstart,
                                                      input logic [XA_W-1:0] vbase);
    return pstart - vbase;
  endfunction

  function automatic logic perm_ok(input logic [PRIV_W-1:0] mask,
                                   input logic [PRIV_W-1:0] kind);
    return |(mask & kind);
  endfunction

  // Fault ordering: missing window, then length, then permission.
  function automatic fault_cls_e classify(input logic any_hit,
                                          input logic in_range,
                                          input logic allowed);
    if (!any_hit)       return FC_NOWIN;
    else if (!in_range) return FC_RANGE;
    else if (!allowed)  return FC_PERM;
    else                return FC_NONE;
  endfunction

endpackage

// File: rtl/xlt_win_regs.sv
module xlt_win_regs
  import xlt_pkg::*;
#(
  parameter int                NUM_WIN    = 4,
  parameter logic [XA_W-1:0]   BASE       = 32'h0010_0000,
  parameter int                SLOT_SHIFT = 12,
  parameter logic [PRIV_W-1:0] PRIV_RST   = 3'b111
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              reg_we,
  input  logic [11:0]                       reg_addr,
  input  logic [XA_W-1:0]                   reg_wdata,
  output logic [XA_W-1:0]                   reg_rdata,
  output logic [NUM_WIN-1:0][XA_W-1:0]      addend_o,
  output logic [NUM_WIN-1:0][XA_W-1:0]      len_o,
  output logic [NUM_WIN-1:0][PRIV_W-1:0]    priv_o,
  output logic                              wr_ignored_o
);

  localparam logic [XA_W-1:0] SLOT_BYTES = XA_W'(1) << SLOT_SHIFT;
  localparam logic [1:0]      FLD_START  = 2'd0;
  localparam logic [1:0]      FLD_LEN    = 2'd1;
  localparam logic [1:0]      FLD_PRIV   = 2'd2;

  logic       in_area;
  logic [5:0] widx;
  logic [1:0] field;
  logic       idx_ok;

  assign in_area      = (reg_addr[11:10] == 2'b01) && (reg_addr[1:0] == 2'b00);
  assign widx         = reg_addr[9:4];
  assign field        = reg_addr[3:2];
  assign idx_ok       = in_area && (32'(widx) < 32'(NUM_WIN));
  assign wr_ignored_o = reg_we && !idx_ok;

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    logic sel;
    assign sel = reg_we && idx_ok && (widx == 6'(gi));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addend_o[gi] <= '0;
        len_o[gi]    <= SLOT_BYTES;
        priv_o[gi]   <= PRIV_RST;
      end else if (sel) begin
        case (field)
          FLD_START: addend_o[gi] <= start_to_addend(reg_wdata,
                                                     slot_vbase(BASE, gi, SLOT_SHIFT));
          FLD_LEN:   len_o[gi]    <= reg_wdata + XA_W'(1);
          FLD_PRIV:  priv_o[gi]   <= reg_wdata[PRIV_W-1:0];
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (idx_ok) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (widx == 6'(i)) begin
          case (field)
            FLD_START: reg_rdata = slot_vbase(BASE, i, SLOT_SHIFT) + addend_o[i];
            FLD_LEN:   reg_rdata = len_o[i];
            FLD_PRIV:  reg_rdata = {{(XA_W-PRIV_W){1'b0}}, priv_o[i]};
            default:   reg_rdata = '0;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/xlt_lookup.sv
module xlt_lookup
  import xlt_pkg::*;
#(
  parameter int              NUM_WIN    = 4,
  parameter logic [XA_W-1:0] BASE       = 32'h0010_0000,
  parameter int              SLOT_SHIFT = 12
) (
  input  logic [XA_W-1:0]                acc_addr,
  input  logic [PRIV_W-1:0]              acc_type,
  input  logic [NUM_WIN-1:0][XA_W-1:0]   addend_i,
  input  logic [NUM_WIN-1:0][XA_W-1:0]   len_i,
  input  logic [NUM_WIN-1:0][PRIV_W-1:0] priv_i,
  output logic [NUM_WIN-1:0]             hit_o,
  output logic [XA_W-1:0]                paddr_o,
  output fault_cls_e                     fclass_o
);

  localparam logic [XA_W-1:0] OFF_MASK = (XA_W'(1) << SLOT_SHIFT) - XA_W'(1);

  logic              below;
  logic [XA_W-1:0]   rel;
  logic [XA_W-1:0]   slot;
  logic [XA_W-1:0]   off;
  logic [XA_W-1:0]   sel_add;
  logic [XA_W-1:0]   sel_len;
  logic [PRIV_W-1:0] sel_prv;

  assign below = acc_addr < BASE;
  assign rel   = acc_addr - BASE;
  assign slot  = rel >> SLOT_SHIFT;
  assign off   = rel & OFF_MASK;

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_hit
    assign hit_o[gi] = !below && (slot == XA_W'(gi));
  end

  always_comb begin
    sel_add = '0;
    sel_len = '0;
    sel_prv = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hit_o[i]) begin
        sel_add = sel_add | addend_i[i];
        sel_len = sel_len | len_i[i];
        sel_prv = sel_prv | priv_i[i];
      end
    end
  end

  assign paddr_o  = acc_addr + sel_add;
  assign fclass_o = classify(|hit_o, off < sel_len, perm_ok(sel_prv, acc_type));

endmodule

// File: rtl/xlt_window_unit.sv
module xlt_window_unit
  import xlt_pkg::*;
#(
  parameter int                NUM_WIN    = 4,
  parameter logic [XA_W-1:0]   BASE       = 32'h0010_0000,
  parameter int                SLOT_SHIFT = 12,
  parameter logic [PRIV_W-1:0] PRIV_RST   = 3'b111
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        acc_valid,
  input  logic [31:0] acc_addr,
  input  logic [2:0]  acc_type,
  output logic [31:0] acc_paddr,
  output logic        acc_fault,
  output logic        fault_event,
  output logic [1:0]  fault_class
);

  logic [NUM_WIN-1:0][XA_W-1:0]   win_addend;
  logic [NUM_WIN-1:0][XA_W-1:0]   win_len;
  logic [NUM_WIN-1:0][PRIV_W-1:0] win_priv;
  logic [NUM_WIN-1:0]             win_hit;
  logic                           wr_ignored;
  fault_cls_e                     fclass_w;

  xlt_win_regs #(
    .NUM_WIN    (NUM_WIN),
    .BASE       (BASE),
    .SLOT_SHIFT (SLOT_SHIFT),
    .PRIV_RST   (PRIV_RST)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .addend_o     (win_addend),
    .len_o        (win_len),
    .priv_o       (win_priv),
    .wr_ignored_o (wr_ignored)
  );

  xlt_lookup #(
    .NUM_WIN    (NUM_WIN),
    .BASE       (BASE),
    .SLOT_SHIFT (SLOT_SHIFT)
  ) u_lookup (
    .acc_addr (acc_addr),
    .acc_type (acc_type),
    .addend_i (win_addend),
    .len_i    (win_len),
    .priv_i   (win_priv),
    .hit_o    (win_hit),
    .paddr_o  (acc_paddr),
    .fclass_o (fclass_w)
  );

  assign acc_fault   = (fclass_w != FC_NONE);
  assign fault_event = acc_valid && acc_fault;

  always_ff @(posedge clk) begin
    if (!rst_n)           fault_class <= FC_NONE;
    else if (fault_event) fault_class <= fclass_w;
  end

endmodule

// File: rtl/xlt_window_unit_chk.sv
module xlt_window_unit_chk
  import xlt_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [11:0]                       reg_addr,
  input logic [31:0]                       reg_rdata,
  input logic                              acc_valid,
  input logic                              acc_fault,
  input logic                              fault_event,
  input logic [1:0]                        fault_class,
  input logic [NUM_WIN-1:0]                win_hit,
  input logic                              wr_ignored,
  input logic [1:0]                        fclass_w,
  input logic [NUM_WIN-1:0][XA_W-1:0]      win_addend,
  input logic [NUM_WIN-1:0][XA_W-1:0]      win_len,
  input logic [NUM_WIN-1:0][PRIV_W-1:0]    win_priv
);

  // R7: at most one slot claims an address
  a_r7_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_hit));

  // R6: writes outside the window array leave every window untouched
  a_r6_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ignored |=> ($stable(win_addend) && $stable(win_len) && $stable(win_priv)));

  // R6: upper half of the register space reads zero
  a_r6_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr[11] |-> (reg_rdata == 32'd0));

  // R11: a qualified fault is captured on the next edge
  a_r11_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_fault) |=> (fault_class == $past(fclass_w)));

  // R11: without a qualified fault the class holds
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_fault) |=> $stable(fault_class));

  // R12: the event only fires for a qualified fault
  a_r12_event: assert property (@(posedge clk) disable iff (!rst_n)
    fault_event |-> (acc_valid && acc_fault));

endmodule

bind xlt_window_unit xlt_window_unit_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_addr    (reg_addr),
  .reg_rdata   (reg_rdata),
  .acc_valid   (acc_valid),
  .acc_fault   (acc_fault),
  .fault_event (fault_event),
  .fault_class (fault_class),
  .win_hit     (win_hit),
  .wr_ignored  (wr_ignored),
  .fclass_w    (fclass_w),
  .win_addend  (win_addend),
  .win_len     (win_len),
  .win_priv    (win_priv)
);

// File: tb/xlt_window_unit_bench.sv
module xlt_window_unit_bench;

  localparam int          NW    = 4;
  localparam logic [31:0] VBASE = 32'h0010_0000;
  localparam int          SH    = 12;
  localparam logic [31:0] SLOT  = 32'd1 << SH;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [2:0]  acc_type = '0;
  logic [31:0] acc_paddr;
  logic        acc_fault;
  logic        fault_event;
  logic [1:0]  fault_class;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_phys [NW];
  logic [31:0] m_len  [NW];
  logic [2:0]  m_prv  [NW];
  logic [1:0]  m_last = 2'd0;

  always #2 clk = ~clk;

  xlt_window_unit #(.NUM_WIN(NW), .BASE(VBASE), .SLOT_SHIFT(SH)) u_xlt_window_unit (
    .clk (clk), .rst_n (rst_n), .reg_we (reg_we), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .acc_valid (acc_valid),
    .acc_addr (acc_addr), .acc_type (acc_type), .acc_paddr (acc_paddr),
    .acc_fault (acc_fault), .fault_event (fault_event), .fault_class (fault_class)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic rd_check(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1 check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic wr_win(input int k, input int fld, input logic [31:0] v);
    wr(12'(1024 + 16 * k + 4 * fld), v);
    if (fld == 0) m_phys[k] = v;
    else if (fld == 1) m_len[k] = v + 32'd1;
    else if (fld == 2) m_prv[k] = v[2:0];
  endtask

  task automatic readback_all(input string tag);
    for (int k = 0; k < NW; k++) begin
      rd_check(12'(1024 + 16 * k),     m_phys[k], tag);
      rd_check(12'(1024 + 16 * k + 4), m_len[k], tag);
      rd_check(12'(1024 + 16 * k + 8), {29'd0, m_prv[k]}, tag);
    end
  endtask

  // Expected class and physical address, straight from the requirements.
  task automatic expect_of(input logic [31:0] a, input logic [2:0] t,
                           output logic [1:0] c, output logic [31:0] p);
    longint unsigned k;
    logic [31:0] off;
    p = '0;
    if (a < VBASE || (longint'(a) - longint'(VBASE)) / longint'(SLOT) >= NW) begin
      c = 2'd1;
    end else begin
      k   = (longint'(a) - longint'(VBASE)) / longint'(SLOT);
      off = 32'(longint'(a) - longint'(VBASE) - longint'(k) * longint'(SLOT));
      p   = m_phys[k] + off;
      if (off >= m_len[k])             c = 2'd2;
      else if ((m_prv[k] & t) == 3'd0) c = 2'd3;
      else                              c = 2'd0;
    end
  endtask

  task automatic access(input logic [31:0] a, input logic [2:0] t, input logic v);
    logic [1:0]  c;
    logic [31:0] p;
    expect_of(a, t, c, p);
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_type = t;
    #1;
    case (c)
      2'd1: check(acc_fault == 1'b1, "R7 no-window fault", 32'(acc_fault), 32'd1);
      2'd2: check(acc_fault == 1'b1, "R8 R10 out-of-range fault", 32'(acc_fault), 32'd1);
      2'd3: check(acc_fault == 1'b1, "R9 no-permission fault", 32'(acc_fault), 32'd1);
      default: begin
        check(acc_fault == 1'b0, "R9 permitted access", 32'(acc_fault), 32'd0);
        check(acc_paddr == p, "R2 translated address", acc_paddr, p);
      end
    endcase
    check(fault_event == (v && c != 2'd0), "R12 fault_event",
          32'(fault_event), 32'(v && c != 2'd0));
    if (v && c != 2'd0) m_last = c;
    @(posedge clk);
    #1;
    check(fault_class == m_last, "R11 R10 fault_class", 32'(fault_class), 32'(m_last));
    acc_valid = 1'b0;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] offs [5];
    logic [2:0]  kinds [4];
    kinds[0] = 3'b001; kinds[1] = 3'b010; kinds[2] = 3'b100; kinds[3] = 3'b011;
    for (int k = 0; k < NW; k++) begin
      m_phys[k] = VBASE + 32'(k) * SLOT;
      m_len[k]  = SLOT;
      m_prv[k]  = 3'b111;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset contents and fault class
    check(fault_class == 2'd0, "R1 fault_class reset", 32'(fault_class), 32'd0);
    readback_all("R1 reset readback");
    access(VBASE + 32'h10, 3'b100, 1'b1);

    // R2 R3 R4 programming (window 2 relocates downward)
    for (int k = 0; k < NW; k++) begin
      wr_win(k, 0, (k == 2) ? 32'h0000_0020 : 32'h8000_0040 + 32'(k) * 32'h0001_0000);
      wr_win(k, 1, (k == 3) ? 32'h0000_0FFF : 32'h100 * 32'(k + 1) - 32'd1);
    end
    wr_win(0, 2, 32'hFFFF_FFF9);   // R4: only bits 2:0 kept -> 1
    wr_win(1, 2, 32'd3);
    wr_win(2, 2, 32'd4);
    wr_win(3, 2, 32'd6);
    readback_all("R2 R3 R4 readback");
    rd_check(12'(1024 + 12), 32'd0, "R5 fourth word reads zero");
    rd_check(12'(1024 + 2), 32'd0, "R5 unaligned reads zero");

    // R6: writes that must not land anywhere
    wr(12'(1024 + 16 * 5), 32'hDEAD_BEEF);
    wr(12'(1024 + 16 * 5 + 4), 32'h0);
    wr(12'h00C, 32'h0);
    wr(12'h800, 32'h1234_5678);
    wr(12'hC04, 32'h0);
    wr(12'(1024 + 12), 32'h5555_5555);
    wr(12'(1024 + 1), 32'h0);
    readback_all("R6 R5 ignored writes");
    rd_check(12'(1024 + 16 * 5), 32'd0, "R6 index beyond N reads zero");
    rd_check(12'h800, 32'd0, "R6 high region reads zero");
    rd_check(12'h004, 32'd0, "R6 low region reads zero");

    // R7 R8 R9 R10 sweep
    for (int k = 0; k < NW; k++) begin
      offs[0] = 32'd0; offs[1] = 32'd1; offs[2] = m_len[k] - 32'd1;
      offs[3] = m_len[k]; offs[4] = 32'hFFF;
      for (int o = 0; o < 5; o++)
        for (int t = 0; t < 4; t++)
          access(VBASE + 32'(k) * SLOT + offs[o], kinds[t], 1'b1);
    end
    access(VBASE - 32'd1, 3'b001, 1'b1);
    access(32'd0, 3'b111, 1'b1);
    access(VBASE + 32'(NW) * SLOT, 3'b001, 1'b1);
    access(32'hFFFF_FFFF, 3'b010, 1'b1);

    // R11 hold and R12 qualification
    access(VBASE + 32'h8, 3'b010, 1'b1);            // class 3
    access(VBASE + 32'h8, 3'b001, 1'b1);            // clean, class holds
    access(VBASE + 32'hF00, 3'b001, 1'b0);          // unqualified range fault
    access(VBASE + 2 * SLOT + 32'h4, 3'b100, 1'b1); // clean
    access(VBASE + SLOT + 32'h300, 3'b001, 1'b1);   // class 2
    check(fault_class == 2'd2, "R11 range class captured", 32'(fault_class), 32'd2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule